// File: doc/BRIEF.md
# Programmable Three-Port Parallel Interface

This block gives a host three byte-wide parallel ports, named A, B and C. The host programs them through an 8-bit register interface with a chip select, separate read and write strobes and a 2-bit register select. A configuration command sets each port's direction and operating style. In the simple style, input lines follow their pins and output lines hold the last value written. In the strobed style, ports A and B each trade a byte with a peripheral under a handshake. Port A can also run a strobed bidirectional style.

In the strobed styles, port C lines stop being general-purpose and carry the handshake. Port A's group uses PC7..PC3 and port B's group uses PC2..PC0. Strobe and acknowledge come in on port C. Buffer-full and interrupt-request flags go out on it. Each interrupt enable is held in the port C latch bit that sits at the position of that handshake input. Reading port C returns a status byte that software can poll instead of taking interrupts.

Every host access takes one clock cycle. A write happens on each rising clock edge that sees `cs_n` and `wr_n` both low. A read happens on each rising edge that sees `cs_n` and `rd_n` both low. `rdata` shows the selected register during that cycle, and any side effect of the read takes place at the edge that ends it.

Top module: `ppi_port`

## Requirements
- R1: After reset, all three ports are inputs in the simple style: `pa_oe`, `pb_oe` and `pc_oe` are 0, and every output latch is 0.
- R2: In the simple style, a read of an input port returns its pins in the same cycle. An output port drives its latch, and its output enable is 1. Register select values are 0 for A, 1 for B, 2 for C and 3 for the command register.
- R3: A write to select 3 with bit 7 = 1 is a configuration command. Bits 6:5 set port A's style (00 simple, 01 strobed, 1x bidirectional). Bit 4 = 1 makes A an input. Bit 3 = 1 makes PC7..PC4 inputs. Bit 2 = 1 makes B strobed. Bit 1 = 1 makes B an input. Bit 0 = 1 makes PC3..PC0 inputs. The command also clears all output latches and handshake flags.
- R4: A write to select 3 with bit 7 = 0 sets or clears one port C latch bit. Bits 3:1 give the bit number and bit 0 gives the value. No other latch bit changes.
- R5: Strobed input: the clock edge that first sees the strobe low latches the port pins and raises buffer-full (A: strobe PC4, buffer-full PC5; B: strobe PC2, buffer-full PC1).
- R6: Strobed input: a strobe returning high raises the interrupt request (A: PC3, B: PC0) when the enable is 1. A host read of the port clears both buffer-full and the request.
- R7: Strobed output on A: a host write drives the active-low buffer-full PC7 to 0 and clears the request PC3. Acknowledge PC6 going low sets PC7 to 1. Acknowledge returning high with the enable at latch bit 6 raises PC3.
- R8: Port B's strobed handshake works on PC2..PC0 independently of port A. For output, buffer-full (active low) is PC1 and acknowledge is PC2.
- R9: In the bidirectional style, port A drives its pins only while PC6 is low. Both the input handshake (PC4, PC5) and the output handshake (PC6, PC7) work, and PC3 is the OR of both requests.
- R10: A read of port C returns handshake outputs at their positions and the enable latch bits at the handshake-input positions. General lines return their pin when they are inputs and their latch when they are outputs.
- R11: A direct write to port C changes only general-purpose output lines. Handshake positions, including the enable bits, keep their latch values.
- R12: A strobe or acknowledge returning high while its enable is 0 does not raise the interrupt request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, 0 when no read is in progress |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A pin output value |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B pin output value |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C pin output value |
| pc_oe | output | 8 | Port C per-line output enable |

## Verification
The embedded properties assume the following about the inputs:
- each host access lasts one cycle;
- read and write are never active together;
- a strobe or acknowledge edge never lands in the same cycle as a host access to that port.

Under those assumptions, the clearing, latching and single-bit update rules hold edge by edge. The directed stimulus respects all three assumptions:
- it changes pins only on falling clock edges;
- it holds every strobe and acknowledge line high when idle;
- it pulses each handshake in a cycle of its own between host accesses.

// File: rtl/ppi_pkg.sv
// Shared types for the parallel port: group styles and the decoded
// configuration word. Assumes an 8-bit command register layout.
package ppi_pkg;

    localparam int PORT_W = 8;

    typedef enum logic [1:0] {
        GRP_SIMPLE  = 2'd0,
        GRP_STROBED = 2'd1,
        GRP_BIDIR   = 2'd2
    } grp_mode_e;

    typedef struct packed {
        grp_mode_e a_mode;
        logic      a_in;
        logic      cu_in;
        logic      b_strobed;
        logic      b_in;
        logic      cl_in;
    } cfg_t;

    // Turn the stored low seven command bits into named fields.
    function automatic cfg_t decode_cw(input logic [6:0] cw);
        cfg_t c;
        if (cw[6])      c.a_mode = GRP_BIDIR;
        else if (cw[5]) c.a_mode = GRP_STROBED;
        else            c.a_mode = GRP_SIMPLE;
        c.a_in      = cw[4];
        c.cu_in     = cw[3];
        c.b_strobed = cw[2];
        c.b_in      = cw[1];
        c.cl_in     = cw[0];
        return c;
    endfunction

endpackage

// File: rtl/ppi_strobe_in.sv
// Strobed input channel: watches an active-low strobe and captures the
// port data on its falling edge. It raises buffer-full on that edge and
// raises an interrupt request on the rising edge when enabled.
// Assumes the strobe is already synchronous to clk.
module ppi_strobe_in #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    input  logic         stb_n,
    input  logic         inte,
    input  logic         rd_evt,
    input  logic [W-1:0] din,
    output logic         ibf,
    output logic         intr,
    output logic [W-1:0] dout
);

    logic stb_q;
    logic fall;
    logic rise;

    assign fall = stb_q && !stb_n;
    assign rise = !stb_q && stb_n;

    // Track the strobe and update the captured byte and flags.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr) begin
            stb_q <= 1'b1;
            ibf   <= 1'b0;
            intr  <= 1'b0;
            dout  <= '0;
        end else begin
            stb_q <= stb_n;
            if (fall) begin
                dout <= din;
                ibf  <= 1'b1;
            end
            if (rise && inte) intr <= 1'b1;
            if (rd_evt) begin
                ibf  <= 1'b0;
                intr <= 1'b0;
            end
        end
    end

    AST_IBF_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && fall && !rd_evt) |=> ibf); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && rd_evt) |=> (!ibf && !intr)); // R6
    AST_INTR_NEEDS_INTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intr) |-> $past(inte)); // R12

endmodule

// File: rtl/ppi_strobe_out.sv
// Strobed output channel: a host write asserts the active-low
// buffer-full flag. The acknowledge falling edge releases it, and the
// rising edge raises an interrupt request when enabled.
// Assumes the acknowledge input is synchronous to clk.
module ppi_strobe_out (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic ack_n,
    input  logic inte,
    input  logic wr_evt,
    output logic obf_n,
    output logic intr
);

    logic ack_q;
    logic fall;
    logic rise;

    assign fall = ack_q && !ack_n;
    assign rise = !ack_q && ack_n;

    // Track the acknowledge and update buffer-full and the request.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr) begin
            ack_q <= 1'b1;
            obf_n <= 1'b1;
            intr  <= 1'b0;
        end else begin
            ack_q <= ack_n;
            if (fall) obf_n <= 1'b1;
            if (rise && inte) intr <= 1'b1;
            if (wr_evt) begin
                obf_n <= 1'b0;
                intr  <= 1'b0;
            end
        end
    end

    AST_OBF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && wr_evt) |=> (!obf_n && !intr)); // R7
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && fall && !wr_evt) |=> obf_n); // R7
    AST_OUT_INTR_NEEDS_INTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intr) |-> $past(inte)); // R12

endmodule

// File: rtl/ppi_port.sv
// Three-port programmable parallel interface. Holds the command
// register and the port latches, and routes port C between general
// lines and the handshake lines of ports A and B.
// Assumes single-cycle host accesses and inputs synchronous to clk.
module ppi_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [7:0] pa_in,
    output logic [7:0] pa_out,
    output logic       pa_oe,
    input  logic [7:0] pb_in,
    output logic [7:0] pb_out,
    output logic       pb_oe,
    input  logic [7:0] pc_in,
    output logic [7:0] pc_out,
    output logic [7:0] pc_oe
);
    import ppi_pkg::*;

    localparam int W = PORT_W;
    localparam logic [1:0] SEL_A   = 2'd0;
    localparam logic [1:0] SEL_B   = 2'd1;
    localparam logic [1:0] SEL_C   = 2'd2;
    localparam logic [1:0] SEL_CTL = 2'd3;
    localparam logic [6:0] CW_RESET = 7'h1B;

    logic [6:0]   cw_q;
    cfg_t         cfg;
    logic [W-1:0] pa_lat, pb_lat, pc_lat;
    logic         wr_evt, rd_evt, mode_set, bsr;
    logic         a_bidir, a_sin, a_sout, b_sin, b_sout;
    logic         ibf_a, intr_ai, obf_a_n, intr_ao;
    logic         ibf_b, intr_bi, obf_b_n, intr_bo;
    logic [W-1:0] a_rx, b_rx;
    logic [7:0]   hs_used, hs_out, hs_val, dir_in, gen_out, gen_in, pc_rd;

    assign cfg      = decode_cw(cw_q);
    assign wr_evt   = !cs_n && !wr_n;
    assign rd_evt   = !cs_n && !rd_n;
    assign mode_set = wr_evt && (addr == SEL_CTL) && wdata[7];
    assign bsr      = wr_evt && (addr == SEL_CTL) && !wdata[7];
    assign a_bidir  = (cfg.a_mode == GRP_BIDIR);
    assign a_sin    = ((cfg.a_mode == GRP_STROBED) && cfg.a_in) || a_bidir;
    assign a_sout   = ((cfg.a_mode == GRP_STROBED) && !cfg.a_in) || a_bidir;
    assign b_sin    = cfg.b_strobed && cfg.b_in;
    assign b_sout   = cfg.b_strobed && !cfg.b_in;

    ppi_strobe_in #(.W(W)) u_a_in (
        .clk(clk), .rst_n(rst_n), .en(a_sin), .clr(mode_set),
        .stb_n(pc_in[4]), .inte(pc_lat[4]),
        .rd_evt(rd_evt && (addr == SEL_A)), .din(pa_in),
        .ibf(ibf_a), .intr(intr_ai), .dout(a_rx)
    );

    ppi_strobe_out u_a_out (
        .clk(clk), .rst_n(rst_n), .en(a_sout), .clr(mode_set),
        .ack_n(pc_in[6]), .inte(pc_lat[6]),
        .wr_evt(wr_evt && (addr == SEL_A)),
        .obf_n(obf_a_n), .intr(intr_ao)
    );

    ppi_strobe_in #(.W(W)) u_b_in (
        .clk(clk), .rst_n(rst_n), .en(b_sin), .clr(mode_set),
        .stb_n(pc_in[2]), .inte(pc_lat[2]),
        .rd_evt(rd_evt && (addr == SEL_B)), .din(pb_in),
        .ibf(ibf_b), .intr(intr_bi), .dout(b_rx)
    );

    ppi_strobe_out u_b_out (
        .clk(clk), .rst_n(rst_n), .en(b_sout), .clr(mode_set),
        .ack_n(pc_in[2]), .inte(pc_lat[2]),
        .wr_evt(wr_evt && (addr == SEL_B)),
        .obf_n(obf_b_n), .intr(intr_bo)
    );

    // Work out which port C lines belong to a handshake, and their values.
    always_comb begin
        hs_used = '0;
        hs_out  = '0;
        if (a_sin) begin
            hs_used[5:3] = 3'b111;
            hs_out[5]    = 1'b1;
            hs_out[3]    = 1'b1;
        end
        if (a_sout) begin
            hs_used[7:6] = 2'b11;
            hs_used[3]   = 1'b1;
            hs_out[7]    = 1'b1;
            hs_out[3]    = 1'b1;
        end
        if (cfg.b_strobed) begin
            hs_used[2:0] = 3'b111;
            hs_out[1:0]  = 2'b11;
        end
        hs_val    = '0;
        hs_val[7] = obf_a_n;
        hs_val[5] = ibf_a;
        hs_val[3] = intr_ai || intr_ao;
        hs_val[1] = b_sin ? ibf_b : obf_b_n;
        hs_val[0] = intr_bi || intr_bo;
    end

    assign dir_in  = {{4{cfg.cu_in}}, {4{cfg.cl_in}}};
    assign gen_out = ~hs_used & ~dir_in;
    assign gen_in  = ~hs_used & dir_in;
    assign pc_out  = (hs_out & hs_val) | (~hs_out & pc_lat);
    assign pc_oe   = hs_out | gen_out;
    assign pc_rd   = (hs_out & hs_val) | (gen_in & pc_in) | (~hs_out & ~gen_in & pc_lat);

    assign pa_out = pa_lat;
    assign pa_oe  = a_bidir ? !pc_in[6] : !cfg.a_in;
    assign pb_out = pb_lat;
    assign pb_oe  = !cfg.b_in;

    // Command register and output latches, updated by host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cw_q   <= CW_RESET;
            pa_lat <= '0;
            pb_lat <= '0;
            pc_lat <= '0;
        end else if (mode_set) begin
            cw_q   <= wdata[6:0];
            pa_lat <= '0;
            pb_lat <= '0;
            pc_lat <= '0;
        end else if (bsr) begin
            pc_lat[wdata[3:1]] <= wdata[0];
        end else if (wr_evt) begin
            case (addr)
                SEL_A:   pa_lat <= wdata;
                SEL_B:   pb_lat <= wdata;
                SEL_C:   pc_lat <= (pc_lat & ~gen_out) | (wdata & gen_out);
                default: ;
            endcase
        end
    end

    // Host read data selection.
    always_comb begin
        rdata = '0;
        if (rd_evt) begin
            case (addr)
                SEL_A: begin
                    if (a_sin)       rdata = a_rx;
                    else if (a_sout) rdata = pa_lat;
                    else             rdata = cfg.a_in ? pa_in : pa_lat;
                end
                SEL_B:   rdata = b_sin ? b_rx : (cfg.b_in ? pb_in : pb_lat);
                SEL_C:   rdata = pc_rd;
                default: rdata = '0;
            endcase
        end
    end

    AST_MODESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_set |=> (pa_out == '0 && pb_out == '0 && pc_lat == '0)); // R3
    AST_BSR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        bsr |=> ($countones(pc_lat ^ $past(pc_lat)) <= 1)); // R4
    AST_CWRITE_KEEPS_HS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && addr == SEL_C) |=> ((pc_lat & $past(hs_used)) == ($past(pc_lat) & $past(hs_used)))); // R11

endmodule

// File: tb/tb_ppi_port.sv
module tb_ppi_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pa_in = '0, pb_in = '0, pc_in = 8'hFF;
    logic [7:0] pa_out, pb_out, pc_out, pc_oe;
    logic       pa_oe, pb_oe;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    ppi_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #2 d = rdata;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    // Hold one port C line low for a single clock edge, then release it.
    task automatic pulse_pc(input int bit_no);
        @(negedge clk);
        pc_in[bit_no] = 1'b0;
        @(negedge clk);
        pc_in[bit_no] = 1'b1;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        pa_in = 8'h5A;
        chk("R1 pa_oe", {7'b0, pa_oe}, 8'h00);
        chk("R1 pb_oe", {7'b0, pb_oe}, 8'h00);
        chk("R1 pc_oe", pc_oe, 8'h00);
        chk("R1 pa_out", pa_out, 8'h00);
        host_rd(2'd0, d);
        chk("R1 R2 read A pins", d, 8'h5A);
    endtask

    task automatic t_simple;
        logic [7:0] d;
        host_wr(2'd3, 8'h82);
        host_wr(2'd0, 8'h3C);
        chk("R2 pa_out", pa_out, 8'h3C);
        chk("R2 pa_oe", {7'b0, pa_oe}, 8'h01);
        pb_in = 8'hA5;
        host_rd(2'd1, d);
        chk("R2 read B", d, 8'hA5);
        pb_in = 8'h11;
        host_rd(2'd1, d);
        chk("R2 read B follows pins", d, 8'h11);
        host_wr(2'd2, 8'h96);
        chk("R2 pc_out", pc_out, 8'h96);
        chk("R2 pc_oe", pc_oe, 8'hFF);
    endtask

    task automatic t_bitset;
        host_wr(2'd3, 8'h01);
        chk("R4 set bit0", pc_out, 8'h97);
        host_wr(2'd3, 8'h0E);
        chk("R4 clear bit7", pc_out, 8'h17);
        host_wr(2'd3, 8'h82);
        chk("R3 mode set clears A", pa_out, 8'h00);
        chk("R3 mode set clears C", pc_out, 8'h00);
    endtask

    task automatic t_strobe_in;
        logic [7:0] d;
        pc_in = 8'hFF;
        host_wr(2'd3, 8'hB6);
        host_wr(2'd3, 8'h09);
        host_rd(2'd2, d);
        chk("R10 status idle", d, 8'h10);
        pa_in = 8'hC3;
        @(negedge clk); pc_in[4] = 1'b0;
        @(negedge clk);
        chk("R5 IBF A", {7'b0, pc_out[5]}, 8'h01);
        chk("R6 no INTR before rise", {7'b0, pc_out[3]}, 8'h00);
        pa_in = 8'h00;
        pc_in[4] = 1'b1;
        @(negedge clk);
        chk("R6 INTR A", {7'b0, pc_out[3]}, 8'h01);
        host_rd(2'd2, d);
        chk("R10 status full", d, 8'h38);
        host_rd(2'd0, d);
        chk("R5 latched A", d, 8'hC3);
        chk("R6 read clears IBF/INTR", {6'b0, pc_out[5], pc_out[3]}, 8'h00);
        pb_in = 8'h7E;
        pulse_pc(2);
        @(negedge clk);
        chk("R8 IBF B", {7'b0, pc_out[1]}, 8'h01);
        chk("R12 no INTR B with enable 0", {7'b0, pc_out[0]}, 8'h00);
        pb_in = 8'h00;
        host_rd(2'd1, d);
        chk("R8 latched B", d, 8'h7E);
        chk("R8 IBF B cleared", {7'b0, pc_out[1]}, 8'h00);
    endtask

    task automatic t_strobe_out;
        logic [7:0] d;
        pc_in = 8'hFF;
        host_wr(2'd3, 8'hA4);
        host_wr(2'd3, 8'h0D);
        host_wr(2'd0, 8'h81);
        chk("R7 pa_out", pa_out, 8'h81);
        chk("R7 OBF A low", {7'b0, pc_out[7]}, 8'h00);
        @(negedge clk); pc_in[6] = 1'b0;
        @(negedge clk);
        chk("R7 ack releases OBF", {7'b0, pc_out[7]}, 8'h01);
        chk("R7 no INTR yet", {7'b0, pc_out[3]}, 8'h00);
        pc_in[6] = 1'b1;
        @(negedge clk);
        chk("R7 INTR on ack rise", {7'b0, pc_out[3]}, 8'h01);
        host_wr(2'd0, 8'h42);
        chk("R7 write clears INTR", {7'b0, pc_out[3]}, 8'h00);
        host_wr(2'd2, 8'hFF);
        host_rd(2'd2, d);
        chk("R11 R10 status after C write", d, 8'h72);
        host_wr(2'd1, 8'h55);
        chk("R8 pb_out", pb_out, 8'h55);
        chk("R8 OBF B low", {7'b0, pc_out[1]}, 8'h00);
    endtask

    task automatic t_bidir;
        logic [7:0] d;
        pc_in = 8'hFF;
        host_wr(2'd3, 8'hC2);
        chk("R9 pc_oe", pc_oe, 8'hAF);
        host_wr(2'd0, 8'h5A);
        chk("R9 no drive without ack", {7'b0, pa_oe}, 8'h00);
        @(negedge clk); pc_in[6] = 1'b0;
        #2;
        chk("R9 drive on ack", {7'b0, pa_oe}, 8'h01);
        chk("R9 drive value", pa_out, 8'h5A);
        @(negedge clk); pc_in[6] = 1'b1;
        pa_in = 8'h24;
        pulse_pc(4);
        @(negedge clk);
        chk("R9 IBF in bidir", {7'b0, pc_out[5]}, 8'h01);
        chk("R9 OBF released", {7'b0, pc_out[7]}, 8'h01);
        host_rd(2'd0, d);
        chk("R9 read latched input", d, 8'h24);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_simple();
        t_bitset();
        t_strobe_in();
        t_strobe_out();
        t_bidir();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule